// File: doc/BRIEF.md
# Colored-Button Sequence Lock

This block is a small synchronous controller that releases a door lock only after an operator arms it with a start button and then enters a four-press color code: red, blue, green, red. Three color buttons feed it, along with a press strobe that an upstream conditioner raises for exactly one cycle whenever a colored button goes down. The lock evaluates the color buttons only in cycles where that strobe is high. In cycles without the strobe, it keeps its current progress.

Every step demands the expected color on its own. Any other strobed pattern sends the lock back to idle: a wrong color, two or more colors together, or no color at all. After that the whole code must be entered again, start press included. When the final red is accepted, the unlock output goes high for a single cycle and the lock then returns to idle. The state is held in a three-bit binary register with a synchronous reset.

Top module: `colorlock`

## Requirements
- R1: While the synchronous reset is high at a rising edge, the lock goes to idle and unlock is 0 after that edge. Reset has priority over every other input.
- R2: In idle, the lock stays in idle while start_btn is 0, whatever the color buttons and the strobe do. A correct strobed code entered without a start press never raises unlock.
- R3: In idle, start_btn = 1 at a rising edge arms the lock. The next strobed color is then judged as the first code press.
- R4: In any armed or part-way state (armed, after first red, after blue, after green), a cycle with press_stb = 0 leaves the state unchanged, whatever the buttons are.
- R5: With press_stb = 1, each step advances only when exactly the expected color is 1 and the other two are 0. The expected colors are red, blue, green, red in that order, and unlock rises in the cycle after the fourth accepted press.
- R6: A strobed press with two or three colors active returns the lock to idle.
- R7: A strobed press of a single wrong color returns the lock to idle.
- R8: A strobe with no color active returns the lock to idle.
- R9: unlock is 1 only in the final state and stays high for exactly one cycle. The lock then returns to idle at the next edge, even if start_btn is held.
- R10: start_btn has no effect in any state other than idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_btn | input | 1 | Start button, arms the lock from idle |
| red_btn | input | 1 | Red button level |
| green_btn | input | 1 | Green button level |
| blue_btn | input | 1 | Blue button level |
| press_stb | input | 1 | One-cycle strobe marking a colored press |
| unlock | output | 1 | Door release, high for one cycle after a correct code |

## Verification
Several rules are checked by assertions on every cycle. These are: holding state when there is no strobe, staying idle when there is no start, the one-cycle unlock pulse, returning to idle on a multi-color press, reset forcing idle, and the requirement that unlock rises only after a lone red strobed from the after-green state. The bench scenarios alone show what can only be seen through the single unlock output. They show that a wrong, empty or combined press really discards progress: each is followed by the remainder of the code, and the bench confirms that no unlock comes out. They also show that start presses outside idle are ignored, and that a reset in the middle of a code discards it.

// File: rtl/colorlock_pkg.sv
package colorlock_pkg;
   localparam int STATE_W = 3;
   localparam int NUM_COLORS = 3;
   localparam int IDX_W = $clog2(NUM_COLORS);

   localparam logic [IDX_W-1:0] IDX_RED = IDX_W'(0);
   localparam logic [IDX_W-1:0] IDX_GREEN = IDX_W'(1);
   localparam logic [IDX_W-1:0] IDX_BLUE = IDX_W'(2);

   typedef enum logic [STATE_W-1:0] {
      ST_IDLE = 3'd0,
      ST_ARMED = 3'd1,
      ST_GOT_R1 = 3'd2,
      ST_GOT_B = 3'd3,
      ST_GOT_G = 3'd4,
      ST_OPEN = 3'd5
   } lock_state_t;

   function automatic logic [IDX_W-1:0] wanted_color(input lock_state_t st);
      case (st)
         ST_ARMED: return IDX_RED;
         ST_GOT_R1: return IDX_BLUE;
         ST_GOT_B: return IDX_GREEN;
         default: return IDX_RED;
      endcase
   endfunction

   function automatic lock_state_t step_after(input lock_state_t st);
      case (st)
         ST_ARMED: return ST_GOT_R1;
         ST_GOT_R1: return ST_GOT_B;
         ST_GOT_B: return ST_GOT_G;
         ST_GOT_G: return ST_OPEN;
         default: return ST_IDLE;
      endcase
   endfunction
endpackage

// File: rtl/colorlock_match.sv
module colorlock_match #(
   parameter int NUM_COLORS = 3,
   localparam int IW = (NUM_COLORS > 1) ? $clog2(NUM_COLORS) : 1
) (
   input  logic [NUM_COLORS-1:0] btns,
   input  logic [IW-1:0]         want,
   output logic                  hit
);
   if (NUM_COLORS < 2) begin : g_bad_count
      $error("colorlock_match: NUM_COLORS must be at least 2");
   end

   logic [NUM_COLORS-1:0] want_oh;

   for (genvar i = 0; i < NUM_COLORS; i++) begin : g_oh
      assign want_oh[i] = (want == IW'(i));
   end

   assign hit = (btns == want_oh);

   always_comb begin
      if (hit) begin
         AST_HIT_SINGLE: assert ($countones(btns) == 1); // R6
      end
   end
endmodule

// File: rtl/colorlock_next.sv
module colorlock_next
   import colorlock_pkg::*;
(
   input  lock_state_t           cur,
   input  logic                  start,
   input  logic                  stb,
   input  logic [NUM_COLORS-1:0] colors,
   output lock_state_t           nxt
);
   logic [IDX_W-1:0] want_idx;
   logic             exact;

   assign want_idx = wanted_color(cur);

   colorlock_match #(.NUM_COLORS(NUM_COLORS)) u_match (
      .btns(colors),
      .want(want_idx),
      .hit (exact)
   );

   always_comb begin
      nxt = cur;
      case (cur)
         ST_IDLE: nxt = start ? ST_ARMED : ST_IDLE;
         ST_ARMED, ST_GOT_R1, ST_GOT_B, ST_GOT_G: begin
            if (stb) nxt = exact ? step_after(cur) : ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end
endmodule

// File: rtl/colorlock_state.sv
module colorlock_state
   import colorlock_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  lock_state_t d,
   output lock_state_t q
);
   always_ff @(posedge clk) begin
      if (rst) q <= ST_IDLE;
      else     q <= d;
   end

   AST_RESET_IDLE: assert property (@(posedge clk) rst |=> q == ST_IDLE); // R1
endmodule

// File: rtl/colorlock.sv
module colorlock
   import colorlock_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic start_btn,
   input  logic red_btn,
   input  logic green_btn,
   input  logic blue_btn,
   input  logic press_stb,
   output logic unlock
);
   lock_state_t           st_q;
   lock_state_t           st_d;
   logic [NUM_COLORS-1:0] colors;
   logic                  mid;

   always_comb begin
      colors = '0;
      colors[IDX_RED] = red_btn;
      colors[IDX_GREEN] = green_btn;
      colors[IDX_BLUE] = blue_btn;
   end

   colorlock_next u_next (
      .cur   (st_q),
      .start (start_btn),
      .stb   (press_stb),
      .colors(colors),
      .nxt   (st_d)
   );

   colorlock_state u_state (
      .clk(clk),
      .rst(rst),
      .d  (st_d),
      .q  (st_q)
   );

   assign unlock = (st_q == ST_OPEN);
   assign mid = (st_q == ST_ARMED) || (st_q == ST_GOT_R1) ||
                (st_q == ST_GOT_B) || (st_q == ST_GOT_G);

   AST_UNLOCK_PULSE: assert property (@(posedge clk) disable iff (rst)
      unlock |=> !unlock); // R9
   AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (rst)
      (mid && !press_stb) |=> $stable(st_q)); // R4
   AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_IDLE && !start_btn) |=> (st_q == ST_IDLE)); // R2
   AST_MULTI_ABORT: assert property (@(posedge clk) disable iff (rst)
      (mid && press_stb && $countones({red_btn, green_btn, blue_btn}) > 1)
      |=> (st_q == ST_IDLE)); // R6
   AST_UNLOCK_SOURCE: assert property (@(posedge clk) disable iff (rst)
      $rose(unlock) |-> ($past(st_q) == ST_GOT_G && $past(press_stb) &&
                         $past(red_btn) && !$past(green_btn) && !$past(blue_btn))); // R5
endmodule

// File: tb/colorlock_test.sv
module colorlock_test;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start_btn = 1'b0;
   logic red_btn = 1'b0;
   logic green_btn = 1'b0;
   logic blue_btn = 1'b0;
   logic press_stb = 1'b0;
   logic unlock;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   colorlock uut (
      .clk(clk), .rst(rst), .start_btn(start_btn), .red_btn(red_btn),
      .green_btn(green_btn), .blue_btn(blue_btn), .press_stb(press_stb),
      .unlock(unlock)
   );

   // Row layout: {req[3:0], start, red, green, blue, stb, expected unlock}
   localparam int NV = 42;
   localparam logic [9:0] VEC [NV] = '{
      {4'd2, 6'b010010}, // R2 strobed red while idle
      {4'd3, 6'b100000}, // R3 arm
      {4'd4, 6'b010000}, // R4 red without strobe
      {4'd5, 6'b010010}, // R5 red
      {4'd5, 6'b000110}, // R5 blue
      {4'd4, 6'b000000}, // R4 idle cycle
      {4'd5, 6'b001010}, // R5 green
      {4'd5, 6'b010011}, // R5 final red -> unlock
      {4'd9, 6'b000000}, // R9 pulse ends
      {4'd2, 6'b010010}, // R2 code without start
      {4'd2, 6'b000110},
      {4'd2, 6'b001010},
      {4'd2, 6'b010010},
      {4'd3, 6'b100000}, // arm
      {4'd6, 6'b010110}, // R6 red+blue together
      {4'd6, 6'b010010},
      {4'd6, 6'b000110},
      {4'd6, 6'b001010},
      {4'd6, 6'b010010}, // would unlock if not aborted
      {4'd3, 6'b100000},
      {4'd7, 6'b010010},
      {4'd7, 6'b001010}, // R7 wrong color
      {4'd7, 6'b000110},
      {4'd7, 6'b001010},
      {4'd7, 6'b010010},
      {4'd3, 6'b100000},
      {4'd8, 6'b010010},
      {4'd8, 6'b000110},
      {4'd8, 6'b000010}, // R8 empty strobe
      {4'd8, 6'b001010},
      {4'd8, 6'b010010},
      {4'd3, 6'b100000},
      {4'd10, 6'b100000}, // R10 start while armed
      {4'd10, 6'b110010},
      {4'd10, 6'b100110},
      {4'd10, 6'b101010},
      {4'd10, 6'b010011},
      {4'd9, 6'b100000}, // R9 start held in final state
      {4'd9, 6'b010010},
      {4'd9, 6'b000110},
      {4'd9, 6'b001010},
      {4'd9, 6'b010010}
   };

   task automatic check(input logic act, input logic exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s unlock=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic drive(input logic s, input logic r, input logic g,
                        input logic b, input logic a);
      @(negedge clk);
      start_btn = s; red_btn = r; green_btn = g; blue_btn = b; press_stb = a;
      @(posedge clk);
      #2;
   endtask

   initial begin
      repeat (2) @(posedge clk);
      #2;
      check(unlock, 1'b0, "R1");
      @(negedge clk);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
         checks++;
         if (unlock !== VEC[i][0]) begin
            errors++;
            $display("FAIL R%0d row %0d unlock=%0b expected=%0b",
                     VEC[i][9:6], i, unlock, VEC[i][0]);
         end
      end

      // R1: reset in the middle of a code discards it
      drive(1, 0, 0, 0, 0);
      drive(0, 1, 0, 0, 1);
      drive(0, 0, 0, 1, 1);
      drive(0, 0, 1, 0, 1);
      @(negedge clk);
      rst = 1'b1;
      drive(1, 0, 0, 0, 0);
      check(unlock, 1'b0, "R1");
      @(negedge clk);
      rst = 1'b0;
      drive(0, 1, 0, 0, 1);
      check(unlock, 1'b0, "R1");
      drive(0, 1, 0, 0, 1);
      drive(0, 0, 0, 1, 1);
      drive(0, 0, 1, 0, 1);
      drive(0, 1, 0, 0, 1);
      check(unlock, 1'b0, "R1");

      // R6: all three colors at the last step
      drive(1, 0, 0, 0, 0);
      drive(0, 1, 0, 0, 1);
      drive(0, 0, 0, 1, 1);
      drive(0, 0, 1, 0, 1);
      drive(0, 1, 1, 1, 1);
      check(unlock, 1'b0, "R6");
      drive(0, 1, 0, 0, 1);
      check(unlock, 1'b0, "R6");

      // R4: long hold after green, then final red
      drive(1, 0, 0, 0, 0);
      drive(0, 1, 0, 0, 1);
      drive(0, 0, 0, 1, 1);
      drive(0, 0, 1, 0, 1);
      for (int k = 0; k < 5; k++) drive(1, 1, 1, 1, 0);
      check(unlock, 1'b0, "R4");
      drive(0, 1, 0, 0, 1);
      check(unlock, 1'b1, "R4");
      drive(0, 0, 0, 0, 0);
      check(unlock, 1'b0, "R9");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule